// File: doc/BRIEF.md
# Multistep Inverter Gate Sequencer

This block drives the nine transistor gate enables of a seven-level stacked H-bridge inverter whose output is a 60 Hz staircase. Each AC period is cut into twelve equal output steps. For every step the block presents a 9-bit switch pattern taken from a twelve-entry table that is fixed at elaboration time. A bit set to one turns its transistor on, and a bit at zero holds it off.

A timed dead-time window separates every pair of neighbouring steps, including the wrap from the last step back to the first. During that window every gate is forced off, so the slow edges of the power devices can never overlap into a crossover path. The dead-time cycles are added to the step length and are not taken out of it. The current step number and a dead-time flag are brought out so that the sequence can be observed.

An active-low clear is synchronised to the clock. It stops the sequence at once and holds every output low. When it is released, the sequence starts again from the first step.

Top module: `stairstep_gate_seq`

## Requirements
- R1: While `clr_n` is low, `gate_en`, `step_idx` and `dead_time` are all zero, at the latest from the next rising clock edge onward.
- R2: After `clr_n` rises, the step-0 pattern appears on `gate_en` at the third rising edge: two synchroniser stages plus one start edge. After the second of those edges the gates are still all zero.
- R3: Outside dead time, `gate_en` equals table row `step_idx`. Row k occupies table bits [9k+8:9k], and bit i of a row drives switch i (1 = on, 0 = off).
- R4: Steps run in the order 0, 1, …, 11 and then wrap to 0. `step_idx` changes only on the edge that ends a dead-time window. During dead time it keeps the number of the step that just finished.
- R5: Every output step lasts exactly STEP_CYC = CLK_HZ / STEP_RATE_HZ clocks, which is 2560 with the default parameters.
- R6: Between any two consecutive steps, including 11 to 0, `dead_time` is high for exactly DEAD_CYC clocks (default 1) and all nine gates are zero.
- R7: One full period, from the start of step 0 to the next start of step 0, takes 12 × (STEP_CYC + DEAD_CYC) clocks, which is 30732 by default.
- R8: The default table, given in hex as row 0 through row 11, is 00E, 08A, 028, 016, 110, 050, 011, 050, 110, 016, 028, 08A.
- R9: Asserting clear in the middle of a period abandons that period. After release the sequence restarts at step 0 with a full-length step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (1.8432 MHz by default) |
| clr_n | input | 1 | Active-low clear, asynchronous to the sequence |
| gate_en | output | 9 | Registered gate enables, bit i drives switch i |
| step_idx | output | 4 | Current (or, during dead time, just completed) step number |
| dead_time | output | 1 | High during the all-off interval between steps |

## Verification
The gates, the step number and the dead-time flag are all flip-flop outputs. They change only on the edge where a phase counter reaches its limit, or on the third edge after clear is released. The bench therefore releases clear on a falling edge, counts exactly three rising edges before it expects the step-0 pattern, and from then on samples every falling edge. At each sample it compares against a position model: position modulo STEP_CYC + DEAD_CYC selects the step or the dead window. Run lengths of the step and dead phases, and the restart of step 0 at position 30732, are measured from those same samples.

// File: rtl/stairstep_pkg.sv
package stairstep_pkg;

  // Structure of the stacked bridge: nine switches, twelve steps per period.
  localparam int SW_W   = 9;
  localparam int STEP_N = 12;
  localparam int IDX_W  = $clog2(STEP_N);
  localparam int TAB_W  = SW_W * STEP_N;

  typedef logic [SW_W-1:0]  gate_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAB_W-1:0] table_t;

  // Row 11 first, row 0 last in the concatenation.
  localparam table_t DEFAULT_TABLE = {
    9'h08A, 9'h028, 9'h016, 9'h110, 9'h050, 9'h011,
    9'h050, 9'h110, 9'h016, 9'h028, 9'h08A, 9'h00E
  };

  // Step order with wrap from the last step back to the first.
  function automatic idx_t step_after(idx_t i);
    return (i == idx_t'(STEP_N - 1)) ? '0 : idx_t'(i + 1'b1);
  endfunction

  // Clocks per output step.
  function automatic int cycles_per_step(int clk_hz, int rate_hz);
    return clk_hz / rate_hz;
  endfunction

  // Row k of a packed table.
  function automatic gate_t pattern_at(table_t tab, idx_t i);
    return tab[int'(i) * SW_W +: SW_W];
  endfunction

endpackage

// File: rtl/seq_clr_sync.sv
module seq_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n_i,
  output logic run_n_o
);

  logic [STAGES-1:0] sh_q;

  // Asynchronous assertion, release after STAGES rising edges.
  always_ff @(posedge clk or negedge clr_n_i) begin
    if (!clr_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign run_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer
  import stairstep_pkg::*;
#(
  parameter int STEP_CYC = 2560,
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic live_o,
  output logic dead_o,
  output idx_t idx_o,
  output idx_t nxt_idx_o,
  output logic ev_start_o,
  output logic ev_step_end_o,
  output logic ev_dead_end_o
);

  localparam int MAXC  = (STEP_CYC > DEAD_CYC) ? STEP_CYC : DEAD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             live_q;
  logic             dead_q;
  idx_t             idx_q;

  assign ev_start_o    = !live_q;
  assign ev_step_end_o = live_q && !dead_q && (cnt_q == CNT_W'(STEP_CYC - 1));
  assign ev_dead_end_o = dead_q && (cnt_q == CNT_W'(DEAD_CYC - 1));
  assign nxt_idx_o     = ev_dead_end_o ? step_after(idx_q) : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
      dead_q <= 1'b0;
      idx_q  <= '0;
    end else if (ev_start_o) begin
      live_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ev_step_end_o) begin
      dead_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ev_dead_end_o) begin
      dead_q <= 1'b0;
      idx_q  <= nxt_idx_o;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign live_o = live_q;
  assign dead_o = dead_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/seq_pattern_sel.sv
module seq_pattern_sel
  import stairstep_pkg::*;
#(
  parameter table_t TABLE = DEFAULT_TABLE
) (
  input  idx_t  idx_i,
  output gate_t pat_o
);

  localparam int ROWS = 1 << IDX_W;

  gate_t rows [ROWS];

  // Unused codes above the last step decode to all-off.
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    if (k < STEP_N) begin : g_used
      assign rows[k] = TABLE[k*SW_W +: SW_W];
    end else begin : g_pad
      assign rows[k] = '0;
    end
  end

  assign pat_o = rows[idx_i];

endmodule

// File: rtl/stairstep_gate_seq.sv
module stairstep_gate_seq
  import stairstep_pkg::*;
#(
  parameter int     CLK_HZ       = 1843200,
  parameter int     STEP_RATE_HZ = 720,
  parameter int     DEAD_CYC     = 1,
  parameter table_t PATTERN      = DEFAULT_TABLE
) (
  input  logic            clk,
  input  logic            clr_n,
  output logic [SW_W-1:0] gate_en,
  output logic [IDX_W-1:0] step_idx,
  output logic            dead_time
);

  localparam int STEP_CYC = cycles_per_step(CLK_HZ, STEP_RATE_HZ);

  // Named internal events, also observed by the bound checker.
  logic  run_n;
  logic  live;
  logic  dead;
  idx_t  idx;
  idx_t  nxt_idx;
  logic  ev_start;
  logic  ev_step_end;
  logic  ev_dead_end;
  gate_t pat_nxt;
  gate_t gate_q;

  seq_clr_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .clr_n_i (clr_n),
    .run_n_o (run_n)
  );

  seq_phase_timer #(.STEP_CYC(STEP_CYC), .DEAD_CYC(DEAD_CYC)) u_timer (
    .clk           (clk),
    .rst_n         (run_n),
    .live_o        (live),
    .dead_o        (dead),
    .idx_o         (idx),
    .nxt_idx_o     (nxt_idx),
    .ev_start_o    (ev_start),
    .ev_step_end_o (ev_step_end),
    .ev_dead_end_o (ev_dead_end)
  );

  seq_pattern_sel #(.TABLE(PATTERN)) u_sel (
    .idx_i (nxt_idx),
    .pat_o (pat_nxt)
  );

  // Gate register: loaded on the same edges that move the phase timer.
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)                        gate_q <= '0;
    else if (ev_start || ev_dead_end)  gate_q <= pat_nxt;
    else if (ev_step_end)              gate_q <= '0;
  end

  assign gate_en   = gate_q;
  assign step_idx  = idx;
  assign dead_time = dead;

endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import stairstep_pkg::*;
#(
  parameter int     STEP_CYC = 2560,
  parameter int     DEAD_CYC = 1,
  parameter table_t PATTERN  = DEFAULT_TABLE
) (
  input logic  clk,
  input logic  clr_n,
  input logic  run_n,
  input logic  live,
  input gate_t gate_en,
  input idx_t  step_idx,
  input logic  dead_time
);

  int step_run;
  int dead_run;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      step_run <= 0;
      dead_run <= 0;
    end else begin
      step_run <= (live && !dead_time) ? step_run + 1 : 0;
      dead_run <= dead_time ? dead_run + 1 : 0;
    end
  end

  a_r1_clear_forces_off: assert property (@(posedge clk)
    !clr_n |=> (gate_en == '0 && step_idx == '0 && !dead_time));

  a_r3_gates_follow_table: assert property (@(posedge clk) disable iff (!run_n)
    (live && !dead_time) |-> gate_en == pattern_at(PATTERN, step_idx));

  a_r4_index_moves_after_dead: assert property (@(posedge clk) disable iff (!run_n)
    !$stable(step_idx) |-> $fell(dead_time));

  a_r4_index_order: assert property (@(posedge clk) disable iff (!run_n)
    $fell(dead_time) |-> step_idx == step_after($past(step_idx)));

  a_r5_step_length: assert property (@(posedge clk) disable iff (!run_n)
    $rose(dead_time) |-> step_run == STEP_CYC);

  a_r6_dead_all_off: assert property (@(posedge clk) disable iff (!run_n)
    dead_time |-> gate_en == '0);

  a_r6_dead_length: assert property (@(posedge clk) disable iff (!run_n)
    $fell(dead_time) |-> dead_run == DEAD_CYC);

endmodule

bind stairstep_gate_seq seq_checker #(
  .STEP_CYC (STEP_CYC),
  .DEAD_CYC (DEAD_CYC),
  .PATTERN  (PATTERN)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .run_n     (run_n),
  .live      (live),
  .gate_en   (gate_en),
  .step_idx  (step_idx),
  .dead_time (dead_time)
);

// File: tb/stairstep_gate_seq_bench.sv
module stairstep_gate_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int S   = 1843200 / 720;
  localparam int D   = 1;
  localparam int SEG = S + D;
  localparam int PER = 12 * SEG;

  // Expected rows, bit i = switch i (R8).
  int tab [12] = '{'h00E, 'h08A, 'h028, 'h016, 'h110, 'h050,
                   'h011, 'h050, 'h110, 'h016, 'h028, 'h08A};

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [8:0] gate_en;
  logic [3:0] step_idx;
  logic       dead_time;

  int n_run = 0;
  int n_fail = 0;

  stairstep_gate_seq u_stairstep_gate_seq (
    .clk       (clk),
    .clr_n     (clr_n),
    .gate_en   (gate_en),
    .step_idx  (step_idx),
    .dead_time (dead_time)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_zero(input string req, input string what);
    chk(gate_en == 9'h0, req, {what, " gates"}, int'(gate_en), 0);
    chk(step_idx == 4'd0, req, {what, " step"}, int'(step_idx), 0);
    chk(dead_time == 1'b0, req, {what, " dead"}, int'(dead_time), 0);
  endtask

  // Release clear on a falling edge; step 0 is due after the third rising edge.
  task automatic t_release(input string req);
    clr_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(gate_en == 9'h0, req, "gates before start edge", int'(gate_en), 0);
    @(negedge clk);
    chk(gate_en == 9'(tab[0]), req, "step0 gates at third edge", int'(gate_en), tab[0]);
    chk(step_idx == 4'd0 && !dead_time, req, "step0 index/flag",
        int'({dead_time, step_idx}), 0);
  endtask

  task automatic t_clear_hold;
    clr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk_zero("R1", "held clear");
  endtask

  // Called at position 0 of a period; returns at position 0 of the next one.
  task automatic t_period(input string tag);
    int bad_gate = 0, bad_idx = 0, bad_dead = 0;
    int ag = 0, eg = 0, ai = 0, ei = 0, ad = 0, ed = 0;
    int run = 0, n_step = 0, n_dead = 0, bad_s = 0, bad_d = 0, s_act = 0, d_act = 0;
    logic prev_dead = 1'b0;
    for (int p = 0; p <= PER; p++) begin
      int pos  = p % PER;
      int seg  = pos / SEG;
      int off  = pos % SEG;
      bit edead = (off >= S);
      int egate = edead ? 0 : tab[seg];
      if (p > 0 && dead_time != prev_dead) begin
        if (prev_dead) begin n_dead++; if (run != D) begin bad_s = bad_s; bad_d++; d_act = run; end end
        else begin n_step++; if (run != S) begin bad_s++; s_act = run; end end
        run = 0;
      end
      run++;
      prev_dead = dead_time;
      if (int'(gate_en) != egate && bad_gate++ == 0) begin ag = int'(gate_en); eg = egate; end
      if (int'(step_idx) != seg && bad_idx++ == 0) begin ai = int'(step_idx); ei = seg; end
      if (dead_time != edead && bad_dead++ == 0) begin ad = int'(dead_time); ed = int'(edead); end
      if (p < PER && off == 0)
        chk(gate_en == 9'(tab[seg]), "R8", $sformatf("%s row %0d", tag, seg),
            int'(gate_en), tab[seg]);
      if (p == PER - 1)
        chk(dead_time && gate_en == 9'h0, "R6", {tag, " wrap 11->0 dead window"},
            int'({dead_time, gate_en}), 'h200);
      if (p == PER)
        chk(gate_en == 9'(tab[0]) && step_idx == 4'd0 && !dead_time, "R7",
            {tag, " step0 restarts after 12*(S+D)"}, int'(gate_en), tab[0]);
      else
        @(negedge clk);
    end
    chk(bad_gate == 0, "R3", {tag, " gates vs table (first mismatch)"}, ag, eg);
    chk(bad_idx == 0, "R4", {tag, " step order (first mismatch)"}, ai, ei);
    chk(bad_dead == 0, "R6", {tag, " dead flag (first mismatch)"}, ad, ed);
    chk(n_step == 12 && bad_s == 0, "R5", {tag, " step lengths"}, s_act, S);
    chk(n_dead == 12 && bad_d == 0, "R6", {tag, " dead lengths"}, d_act, D);
  endtask

  task automatic t_mid_clear;
    repeat (5 * SEG + 10) @(negedge clk);
    chk(step_idx == 4'd5, "R4", "reached step 5 before clear", int'(step_idx), 5);
    clr_n = 1'b0;
    #1;
    chk_zero("R9", "immediately after mid-period clear");
    @(negedge clk);
    chk_zero("R1", "one edge into clear");
    t_release("R9");
    t_period("R9 restart");
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_clear_hold();
    t_release("R2");
    t_period("P1");
    t_period("P2");
    t_mid_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule